// File: doc/BRIEF.md
# Flash Write-State Controller with Lock Protection

This block is the sequencing core of a parallel NOR-style flash device. It takes decoded commands (erase a block, write a byte, change lock protection, suspend, resume), runs each accepted operation as a busy interval of a set number of clock cycles, and reports progress on a ready/busy pin and a small status word. The flash array and its analog programming circuitry are not modelled. Operation lengths are parameterised cycle counts.

Write protection has two layers. Each of the sixteen 64 KB blocks has its own lock bit, and that bit guards erase and byte write to the block. A separate master lock bit guards every command that changes lock bits. A command that a lock refuses does not start a busy interval. It returns an error flag at once. An erase can be suspended so that a byte write can run to another block, and on resume the erase continues from where it stopped. A power-down pin parks the controller, clears its status and blocks all writes. After the pin is released, a wake interval must pass before commands are taken again.

Top module: `flash_wsm_ctrl`

## Requirements
- R1: The block index is `cmd_addr[19:16]`, one lock bit per block on `blk_lock_o[15:0]`. A set-block-lock operation sets the addressed bit when it completes. A set-master operation sets `master_lock_o`. A clear operation zeroes all sixteen block bits and leaves the master bit unchanged.
- R2: Status bits are: bit0 done, bit1 rejected, bit2 erase suspended, bit3 write suspended. An erase or byte write aimed at a locked block is refused. `ready_o` stays high, the status reads 4'b0010 on the next cycle, and no busy interval follows.
- R3: While `master_lock_o` is set, every lock-changing command is refused in the same way as R2, and the lock bits keep their values.
- R4: An accepted erase, byte write or lock command drives `ready_o` low from the cycle after acceptance. It stays low for exactly ERASE_CYC, WRITE_CYC or LOCK_CYC cycles. The done bit is then set. Any accepted command clears both the done bit and the rejected bit.
- R5: `ready_o` is high in each of these conditions: idle, erase suspended, byte write suspended, and `pwr_n` low.
- R6: While `pwr_n` is low, the controller abandons any running operation, the status reads zero from the next cycle, lock bits do not change, and commands are ignored.
- R7: After the first clock edge that samples `pwr_n` high, `ready_o` stays low for WAKE_CYC cycles, and commands in that interval are ignored.
- R8: A suspend during an erase makes `ready_o` high with status bit2 set. A resume continues the erase, so its busy cycles before and after the suspend add up to ERASE_CYC.
- R9: While an erase is suspended, a byte write to an unlocked block other than the erasing block runs WRITE_CYC cycles and then returns to the erase-suspended state with done set. A write to the erasing block is refused. A suspend during this write is ignored.
- R10: A suspend during a stand-alone byte write sets status bit3 with `ready_o` high. A resume finishes the write, so the total busy time equals WRITE_CYC.
- R11: `cmd_code` encodings are: 0 none, 1 erase, 2 byte write, 3 set block lock, 4 set master lock, 5 clear block locks, 6 suspend, 7 resume. During a busy interval every command except suspend is ignored. Every command is ignored while `ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; clears all state, lock bits included |
| pwr_n | input | 1 | Active-low deep power-down |
| ce_n | input | 1 | Active-low enable; commands count only while low |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 3 | Command encoding (R11) |
| cmd_addr | input | 20 | Byte address; upper four bits select the block |
| ready_o | output | 1 | High = ready, suspended or powered down; low = busy |
| status_o | output | 4 | {write suspended, erase suspended, rejected, done} |
| blk_lock_o | output | 16 | Per-block lock bits |
| master_lock_o | output | 1 | Master lock bit |

## Verification
Erase and write are driven against a random lock mask, with random low address bits. This separates the index taken from the upper address bits from any use of the lower bits, and it separates refusal from acceptance. Directed sequences place suspend at known cycle counts into erase and write. Measuring the busy time after resume then shows whether the countdown resumed or restarted. Power-down is applied in the middle of an erase and in the middle of a lock operation. This shows whether the work was abandoned and whether the lock bits stayed as they were. Commands sent during busy, during wake, with `ce_n` high and under the master lock must leave the busy length, the status and the lock bits as they were.

// File: rtl/fwsm_pkg.sv
package fwsm_pkg;
   typedef enum logic [2:0] {
      CMD_NOP        = 3'd0,
      CMD_ERASE      = 3'd1,
      CMD_WRITE      = 3'd2,
      CMD_SET_BLK    = 3'd3,
      CMD_SET_MASTER = 3'd4,
      CMD_CLR_LOCKS  = 3'd5,
      CMD_SUSPEND    = 3'd6,
      CMD_RESUME     = 3'd7
   } fwsm_cmd_e;

   typedef enum logic [2:0] {
      ST_READY, ST_ERASE, ST_ESUSP, ST_WRITE, ST_WSUSP, ST_LOCKCFG, ST_WAKE
   } fwsm_state_e;

   typedef enum logic [1:0] {
      LK_NONE, LK_SET_BLK, LK_SET_MASTER, LK_CLEAR
   } fwsm_lkop_e;

   localparam int STS_DONE  = 0;
   localparam int STS_REJ   = 1;
   localparam int STS_ESUSP = 2;
   localparam int STS_WSUSP = 3;
   localparam int STS_W     = 4;
endpackage

// File: rtl/fwsm_cycle_timer.sv
module fwsm_cycle_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clear)                cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign last = run && (cnt_q == CNT_W'(1));

   // the controller must never run a countdown that is already exhausted
   AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q != '0)); // R8
endmodule

// File: rtl/fwsm_lock_bank.sv
module fwsm_lock_bank
   import fwsm_pkg::*;
#(
   parameter int BLK_W   = 4,
   parameter int NUM_BLK = 1 << BLK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               apply,
   input  fwsm_lkop_e         lkop,
   input  logic [BLK_W-1:0]   blk,
   output logic [NUM_BLK-1:0] blk_lock,
   output logic               master
);
   for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            blk_lock[i] <= 1'b0;
         else if (apply && lkop == LK_CLEAR)
            blk_lock[i] <= 1'b0;
         else if (apply && lkop == LK_SET_BLK && blk == BLK_W'(i))
            blk_lock[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            master <= 1'b0;
      else if (apply && lkop == LK_SET_MASTER) master <= 1'b1;
   end

   AST_MASTER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      master |=> $stable(blk_lock)); // R3
endmodule

// File: rtl/flash_wsm_ctrl.sv
module flash_wsm_ctrl
   import fwsm_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int BLK_W      = 4,
   parameter int CNT_W      = 16,
   parameter int ERASE_CYC  = 1000,
   parameter int WRITE_CYC  = 20,
   parameter int LOCK_CYC   = 50,
   parameter int WAKE_CYC   = 30,
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pwr_n,
   input  logic                     ce_n,
   input  logic                     cmd_valid,
   input  logic [2:0]               cmd_code,
   input  logic [ADDR_W-1:0]        cmd_addr,
   output logic                     ready_o,
   output logic [STS_W-1:0]         status_o,
   output logic [(1<<BLK_W)-1:0]    blk_lock_o,
   output logic                     master_lock_o
);
   localparam int NUM_BLK = 1 << BLK_W;
   localparam int CNT_MAX = (1 << CNT_W) - 2;
   localparam logic [CNT_W-1:0] ER_LEN = CNT_W'(ERASE_CYC);
   localparam logic [CNT_W-1:0] WR_LEN = CNT_W'(WRITE_CYC);
   localparam logic [CNT_W-1:0] LK_LEN = CNT_W'(LOCK_CYC);
   localparam logic [CNT_W-1:0] WK_LEN = CNT_W'(WAKE_CYC + 1);

   if (BLK_W < 1 || BLK_W >= ADDR_W) begin : g_bad_blk
      $error("BLK_W must lie between 1 and ADDR_W-1");
   end
   if (ERASE_CYC < 2 || ERASE_CYC > CNT_MAX) begin : g_bad_er
      $error("ERASE_CYC out of range for CNT_W");
   end
   if (WRITE_CYC < 3 || WRITE_CYC > CNT_MAX) begin : g_bad_wr
      $error("WRITE_CYC out of range for CNT_W");
   end
   if (LOCK_CYC < 2 || LOCK_CYC > CNT_MAX) begin : g_bad_lk
      $error("LOCK_CYC out of range for CNT_W");
   end
   if (WAKE_CYC < 1 || WAKE_CYC > CNT_MAX) begin : g_bad_wk
      $error("WAKE_CYC out of range for CNT_W");
   end

   logic susp_ok;
   if (SUSPEND_EN) begin : g_susp_on
      assign susp_ok = 1'b1;
   end else begin : g_susp_off
      assign susp_ok = 1'b0;
   end

   fwsm_cmd_e          cmd;
   logic [BLK_W-1:0]   blk;
   logic               cmd_go, tgt_locked, addr_lo_unused;
   logic [NUM_BLK-1:0] blk_lock;
   logic               master;

   assign cmd            = fwsm_cmd_e'(cmd_code);
   assign blk            = cmd_addr[ADDR_W-1 -: BLK_W];
   assign addr_lo_unused = ^cmd_addr[ADDR_W-BLK_W-1:0];
   assign cmd_go         = cmd_valid && !ce_n && pwr_n;
   assign tgt_locked     = blk_lock[blk];

   fwsm_state_e      state_q, state_d;
   logic             nested_q, nested_d;
   logic [BLK_W-1:0] eblk_q, eblk_d, lkblk_q, lkblk_d;
   fwsm_lkop_e       lkop_q, lkop_d;
   logic             done_q, rej_q;
   logic             er_load, wr_load, cmd_acc, cmd_rej, op_fin, lk_apply;
   logic [CNT_W-1:0] wr_len;
   logic             er_last, wr_last, wk_last;

   always_comb begin
      state_d  = state_q;
      nested_d = nested_q;
      eblk_d   = eblk_q;
      lkblk_d  = lkblk_q;
      lkop_d   = lkop_q;
      er_load  = 1'b0;
      wr_load  = 1'b0;
      wr_len   = WR_LEN;
      cmd_acc  = 1'b0;
      cmd_rej  = 1'b0;
      op_fin   = 1'b0;
      lk_apply = 1'b0;
      case (state_q)
         ST_WAKE: if (wk_last) state_d = ST_READY;
         ST_READY: if (cmd_go) begin
            case (cmd)
               CMD_ERASE:
                  if (tgt_locked) cmd_rej = 1'b1;
                  else begin
                     cmd_acc = 1'b1; er_load = 1'b1; eblk_d = blk; state_d = ST_ERASE;
                  end
               CMD_WRITE:
                  if (tgt_locked) cmd_rej = 1'b1;
                  else begin
                     cmd_acc = 1'b1; wr_load = 1'b1; nested_d = 1'b0; state_d = ST_WRITE;
                  end
               CMD_SET_BLK, CMD_SET_MASTER, CMD_CLR_LOCKS:
                  if (master) cmd_rej = 1'b1;
                  else begin
                     cmd_acc = 1'b1; wr_load = 1'b1; wr_len = LK_LEN; lkblk_d = blk;
                     lkop_d  = (cmd == CMD_SET_BLK)    ? LK_SET_BLK :
                               (cmd == CMD_SET_MASTER) ? LK_SET_MASTER : LK_CLEAR;
                     state_d = ST_LOCKCFG;
                  end
               default: ;
            endcase
         end
         ST_ERASE:
            if (er_last) begin
               op_fin = 1'b1; state_d = ST_READY;
            end else if (cmd_go && cmd == CMD_SUSPEND && susp_ok) begin
               cmd_acc = 1'b1; state_d = ST_ESUSP;
            end
         ST_ESUSP: if (cmd_go) begin
            if (cmd == CMD_WRITE) begin
               if (tgt_locked || blk == eblk_q) cmd_rej = 1'b1;
               else begin
                  cmd_acc = 1'b1; wr_load = 1'b1; nested_d = 1'b1; state_d = ST_WRITE;
               end
            end else if (cmd == CMD_RESUME) begin
               cmd_acc = 1'b1; state_d = ST_ERASE;
            end
         end
         ST_WRITE:
            if (wr_last) begin
               op_fin = 1'b1; nested_d = 1'b0;
               state_d = nested_q ? ST_ESUSP : ST_READY;
            end else if (cmd_go && cmd == CMD_SUSPEND && susp_ok && !nested_q) begin
               cmd_acc = 1'b1; state_d = ST_WSUSP;
            end
         ST_WSUSP:
            if (cmd_go && cmd == CMD_RESUME) begin
               cmd_acc = 1'b1; state_d = ST_WRITE;
            end
         ST_LOCKCFG:
            if (wr_last) begin
               op_fin = 1'b1; lk_apply = 1'b1; state_d = ST_READY;
            end
         default: state_d = ST_READY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_READY;
         nested_q <= 1'b0;
         eblk_q   <= '0;
         lkblk_q  <= '0;
         lkop_q   <= LK_NONE;
         done_q   <= 1'b0;
         rej_q    <= 1'b0;
      end else if (!pwr_n) begin
         state_q  <= ST_WAKE;
         nested_q <= 1'b0;
         done_q   <= 1'b0;
         rej_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         nested_q <= nested_d;
         eblk_q   <= eblk_d;
         lkblk_q  <= lkblk_d;
         lkop_q   <= lkop_d;
         if (cmd_acc) begin
            done_q <= 1'b0; rej_q <= 1'b0;
         end else if (cmd_rej) begin
            done_q <= 1'b0; rej_q <= 1'b1;
         end else if (op_fin) begin
            done_q <= 1'b1;
         end
      end
   end

   fwsm_cycle_timer #(.CNT_W(CNT_W)) u_erase_tmr (
      .clk(clk), .rst_n(rst_n), .clear(!pwr_n), .load(er_load), .load_val(ER_LEN),
      .run(state_q == ST_ERASE), .last(er_last));

   fwsm_cycle_timer #(.CNT_W(CNT_W)) u_write_tmr (
      .clk(clk), .rst_n(rst_n), .clear(!pwr_n), .load(wr_load), .load_val(wr_len),
      .run(state_q == ST_WRITE || state_q == ST_LOCKCFG), .last(wr_last));

   fwsm_cycle_timer #(.CNT_W(CNT_W)) u_wake_tmr (
      .clk(clk), .rst_n(rst_n), .clear(1'b0), .load(!pwr_n), .load_val(WK_LEN),
      .run(state_q == ST_WAKE && pwr_n), .last(wk_last));

   fwsm_lock_bank #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_locks (
      .clk(clk), .rst_n(rst_n), .apply(lk_apply && pwr_n), .lkop(lkop_q),
      .blk(lkblk_q), .blk_lock(blk_lock), .master(master));

   assign ready_o = !pwr_n || state_q == ST_READY || state_q == ST_ESUSP
                    || state_q == ST_WSUSP;
   assign status_o = {state_q == ST_WSUSP, state_q == ST_ESUSP, rej_q, done_q};
   assign blk_lock_o    = blk_lock;
   assign master_lock_o = master;

   AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY && cmd_go && cmd == CMD_ERASE && !tgt_locked)
      |=> (!ready_o || !pwr_n)); // R4
   AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY && cmd_go && (cmd == CMD_ERASE || cmd == CMD_WRITE) && tgt_locked)
      |=> (ready_o && status_o[STS_REJ])); // R2
   AST_MASTER_BLOCKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY && cmd_go && master_lock_o &&
       (cmd == CMD_SET_BLK || cmd == CMD_SET_MASTER || cmd == CMD_CLR_LOCKS))
      |=> (ready_o && status_o[STS_REJ])); // R3
   AST_PDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_n |=> (status_o == '0)); // R6
endmodule

// File: tb/flash_wsm_ctrl_tb_top.sv
module flash_wsm_ctrl_tb_top;
   localparam int ER = 40, WR = 6, LK = 10, WK = 12;
   localparam logic [2:0] C_ERASE = 3'd1, C_WRITE = 3'd2, C_SETB = 3'd3,
                          C_SETM = 3'd4, C_CLR = 3'd5, C_SUSP = 3'd6, C_RES = 3'd7;

   logic        clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b1, ce_n = 1'b0, cmd_valid = 1'b0;
   logic [2:0]  cmd_code = 3'd0;
   logic [19:0] cmd_addr = '0;
   logic        ready_o, master_lock_o;
   logic [3:0]  status_o;
   logic [15:0] blk_lock_o;
   int checks = 0, fails = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   flash_wsm_ctrl #(.ADDR_W(20), .BLK_W(4), .CNT_W(8), .ERASE_CYC(ER),
      .WRITE_CYC(WR), .LOCK_CYC(LK), .WAKE_CYC(WK), .SUSPEND_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .ce_n(ce_n), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_addr(cmd_addr), .ready_o(ready_o), .status_o(status_o),
      .blk_lock_o(blk_lock_o), .master_lock_o(master_lock_o));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] c, input int blk);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; cmd_addr = {4'(blk), 16'($urandom)};
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 3'd0;
   endtask

   task automatic wait_busy(output int n);
      n = 0;
      while (!ready_o) begin n++; @(negedge clk); end
   endtask

   function automatic int op_len(input logic [2:0] c);
      return (c == C_ERASE) ? ER : (c == C_WRITE) ? WR : LK;
   endfunction

   function automatic bit refused(input logic [15:0] mask, input int blk);
      return mask[blk];
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      logic [15:0] mask;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5", "ready after reset", ready_o, 1);
      chk("R2", "status after reset", status_o, 0);
      chk("R1", "locks after reset", {master_lock_o, blk_lock_o}, 0);

      send(C_ERASE, 3); wait_busy(n);
      chk("R4", "erase busy length", n, ER);
      chk("R4", "done after erase", status_o, 4'b0001);

      send(C_SETB, 5); wait_busy(n);
      chk("R4", "lock busy length", n, LK);
      chk("R1", "block 5 locked", blk_lock_o, 16'h0020);

      send(C_ERASE, 5);
      chk("R2", "locked erase ready", ready_o, 1);
      chk("R2", "locked erase status", status_o, 4'b0010);
      send(C_WRITE, 5);
      chk("R2", "locked write status", status_o, 4'b0010);
      chk("R2", "locks kept", blk_lock_o, 16'h0020);

      send(C_CLR, 0); wait_busy(n);
      chk("R1", "clear locks", blk_lock_o, 0);

      // a write issued in the middle of an erase must not shorten or extend it
      send(C_ERASE, 0); send(C_WRITE, 1); wait_busy(n);
      chk("R11", "busy cmd ignored", n + 2, ER);
      chk("R11", "done after erase", status_o, 4'b0001);

      ce_n = 1'b1; send(C_ERASE, 0);
      chk("R11", "ce_n high ready", ready_o, 1);
      chk("R11", "ce_n high status", status_o, 4'b0001);
      ce_n = 1'b0;

      // erase suspend: 1 + 9 + 1 busy cycles are used before the suspend edge
      send(C_ERASE, 2);
      repeat (9) @(negedge clk);
      send(C_SUSP, 0);
      chk("R8", "suspended ready", ready_o, 1);
      chk("R8", "suspended status", status_o, 4'b0100);
      repeat (15) @(negedge clk);
      chk("R5", "ready while erase suspended", ready_o, 1);
      send(C_WRITE, 7); wait_busy(n);
      chk("R9", "nested write length", n, WR);
      chk("R9", "back to erase suspend", status_o, 4'b0101);
      send(C_WRITE, 7); send(C_SUSP, 0); wait_busy(n);
      chk("R9", "nested suspend ignored", n + 2, WR);
      send(C_WRITE, 2);
      chk("R9", "write to erasing block", status_o, 4'b0110);
      send(C_RES, 0); wait_busy(n);
      chk("R8", "erase remainder", n, ER - 11);
      chk("R8", "done after resume", status_o, 4'b0001);

      send(C_WRITE, 1); send(C_SUSP, 0);
      chk("R10", "write suspend status", status_o, 4'b1000);
      chk("R5", "ready while write suspended", ready_o, 1);
      repeat (5) @(negedge clk);
      send(C_RES, 0); wait_busy(n);
      chk("R10", "write remainder", n, WR - 2);
      chk("R10", "done after write", status_o, 4'b0001);

      send(C_ERASE, 4);
      repeat (5) @(negedge clk);
      pwr_n = 1'b0; #1;
      chk("R5", "ready in power-down", ready_o, 1);
      @(negedge clk);
      chk("R6", "status cleared", status_o, 0);
      send(C_SETB, 9);
      chk("R6", "cmd in power-down", blk_lock_o[9], 0);
      @(negedge clk);
      pwr_n = 1'b1; cmd_valid = 1'b1; cmd_code = C_ERASE; cmd_addr = '0;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 3'd0;
      wait_busy(n);
      chk("R7", "wake length", n, WK);
      @(negedge clk);
      chk("R7", "cmd during wake ignored", {ready_o, status_o}, 5'b10000);

      send(C_SETB, 10);
      repeat (3) @(negedge clk);
      pwr_n = 1'b0; @(negedge clk); pwr_n = 1'b1;
      @(negedge clk); wait_busy(n);
      chk("R6", "lock op abandoned", blk_lock_o, 0);

      mask = 16'($urandom);
      for (int b = 0; b < 16; b++) begin
         if (mask[b]) begin send(C_SETB, b); wait_busy(n); end
      end
      chk("R1", "random lock mask", blk_lock_o, mask);
      for (int i = 0; i < 24; i++) begin
         int bk = int'($urandom % 16);
         logic [2:0] c = ($urandom % 2) ? C_ERASE : C_WRITE;
         send(c, bk);
         if (refused(mask, bk)) begin
            chk("R2", "random refuse", {ready_o, status_o}, 5'b10010);
         end else begin
            wait_busy(n);
            chk("R4", "random length", n, op_len(c));
            chk("R4", "random done", status_o, 4'b0001);
         end
      end
      send(C_CLR, 0); wait_busy(n);
      chk("R1", "clear after random", blk_lock_o, 0);

      send(C_SETM, 0); wait_busy(n);
      chk("R4", "master busy length", n, LK);
      chk("R1", "master set", master_lock_o, 1);
      send(C_SETB, 6);
      chk("R3", "set block refused", {ready_o, status_o}, 5'b10010);
      chk("R3", "locks unchanged", blk_lock_o, 0);
      send(C_CLR, 0);
      chk("R3", "clear refused", status_o, 4'b0010);
      send(C_SETM, 0);
      chk("R3", "master refused", {ready_o, status_o}, 5'b10010);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule